// File: doc/BRIEF.md
# Storage Channel Mode and Reset Controller

This block is the control slice for one storage channel. Software reaches it through a narrow write and read register port. It tracks whether the channel runs in register mode (programmed I/O through the task-file path) or in packet mode (a DMA packet engine owns the channel). It turns writes to two byte-wide control registers into one-cycle pulses: a channel-logic reset, a serial-link PHY reset and an error clear. It also holds the 64-bit base address of the command block and its size exponent.

A packet is launched by writing one particular command word to a doorbell register. If the channel is in register mode at that moment, it enters packet mode and emits a one-cycle start request to the packet engine. When the engine reports completion, the channel drops back to register mode. A channel reset always forces register mode and clears the latched error. The packet engine, the PHY and the task-file registers sit outside this block.

The channel answers only inside its own 16 KiB window of the address space, selected by a parameter. The asynchronous active-low reset is released synchronously, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `chan_mode_ctl`

## Requirements
- R1: After reset the channel is in register mode, no pulse is active, the error flag is 0, the base address is 0 and the size exponent is 6. Reading offset 0x900 returns 0x02 and reading 0x718 returns 6. An asynchronous reset taken in packet mode returns the channel to register mode at once.
- R2: The window is selected by address bits [ADDR_W-1:14], which must equal CHAN_ID. A write to any other window changes no state and causes no pulse.
- R3: Writing 0x107 to the doorbell at offset 0xA00 while in register mode sets packet mode in the next cycle and raises `pkt_start` for exactly that one cycle.
- R4: A doorbell write with any value other than 0x107 is ignored. A doorbell write of 0x107 while already in packet mode is also ignored and raises no start.
- R5: A `pkt_done` pulse in packet mode returns the channel to register mode in the next cycle. In register mode, `pkt_done` has no effect.
- R6: Writing control-0 (offset 0x900) with bit 1 set forces register mode in the next cycle.
- R7: `err_evt` sets the latched error flag. Writing control-0 with bit 2 set raises `err_clr` for one cycle and clears the flag. If a clear and an event arrive in the same cycle, the clear wins.
- R8: Writing control-1 (offset 0x901) with bit 1 set raises `phy_rst` for one cycle.
- R9: Writing control-1 with bit 4 set raises `chan_rst` for one cycle, forces register mode and clears the error flag.
- R10: Control-0 reads back bit 1 as 1 in register mode and 0 in packet mode; all of its other bits read 0. Control-1 always reads 0.
- R11: Offset 0x710 holds the low 32 bits of the command-block base and offset 0x714 holds the high 32 bits. Each half is written separately, leaves the other half unchanged, and reads back.
- R12: Offset 0x718 holds the command-block size exponent, which is written, driven on `cb_exp` and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (16) | Byte address of the access |
| wdata | input | DATA_W (32) | Write data, right-justified |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| pkt_done | input | 1 | Packet engine completion |
| err_evt | input | 1 | Channel error event |
| pkt_mode | output | 1 | 1 while in packet mode |
| pkt_start | output | 1 | One-cycle packet start request |
| err_clr | output | 1 | One-cycle error clear pulse |
| phy_rst | output | 1 | One-cycle PHY reset pulse |
| chan_rst | output | 1 | One-cycle channel-logic reset pulse |
| err_flag | output | 1 | Latched channel error |
| cb_base | output | 2*DATA_W (64) | Command-block base address |
| cb_exp | output | EXP_W (8) | Command-block size exponent |

## Verification
If the mode register is wrong, the fault shows up one cycle after the offending write or completion. It appears on `pkt_mode` and in bit 1 of control-0. A lost or extra doorbell decode shows at once as a missing or duplicated `pkt_start`, and the refused second doorbell covers the duplicated case. A faulty pulse register shows as a pulse that lasts longer than one cycle, or as a nonzero read of a pulse bit. A wrong error-latch priority shows in `err_flag` on the cycle after the colliding event and clear.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_PKT = 1'b1
  } chan_mode_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL0,
    SEL_CTL1,
    SEL_DOOR,
    SEL_BASE_LO,
    SEL_BASE_HI,
    SEL_EXP
  } reg_sel_e;

  // offsets inside a channel window
  localparam logic [15:0] OFS_CTL0    = 16'h0900;
  localparam logic [15:0] OFS_CTL1    = 16'h0901;
  localparam logic [15:0] OFS_DOOR    = 16'h0A00;
  localparam logic [15:0] OFS_BASE_LO = 16'h0710;
  localparam logic [15:0] OFS_BASE_HI = 16'h0714;
  localparam logic [15:0] OFS_EXP     = 16'h0718;

  // control bit positions
  localparam int CTL0_REG_BIT = 1;
  localparam int CTL0_CLR_BIT = 2;
  localparam int CTL1_PHY_BIT = 1;
  localparam int CTL1_CHN_BIT = 4;

  localparam logic [31:0] DOOR_RUN = 32'h0000_0107;

endpackage

// File: rtl/chan_addr_dec.sv
module chan_addr_dec
  import chan_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 14,
  parameter int CHAN_ID  = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int CH_W = ADDR_W - WIN_LOG2;
  localparam logic [WIN_LOG2-1:0] L_CTL0 = WIN_LOG2'(OFS_CTL0);
  localparam logic [WIN_LOG2-1:0] L_CTL1 = WIN_LOG2'(OFS_CTL1);
  localparam logic [WIN_LOG2-1:0] L_DOOR = WIN_LOG2'(OFS_DOOR);
  localparam logic [WIN_LOG2-1:0] L_BLO  = WIN_LOG2'(OFS_BASE_LO);
  localparam logic [WIN_LOG2-1:0] L_BHI  = WIN_LOG2'(OFS_BASE_HI);
  localparam logic [WIN_LOG2-1:0] L_EXP  = WIN_LOG2'(OFS_EXP);

  logic                in_win;
  logic [WIN_LOG2-1:0] ofs;

  always_comb begin
    in_win = (addr[ADDR_W-1:WIN_LOG2] == CH_W'(CHAN_ID));
    ofs    = addr[WIN_LOG2-1:0];
    sel    = SEL_NONE;
    if (in_win) begin
      case (ofs)
        L_CTL0:  sel = SEL_CTL0;
        L_CTL1:  sel = SEL_CTL1;
        L_DOOR:  sel = SEL_DOOR;
        L_BLO:   sel = SEL_BASE_LO;
        L_BHI:   sel = SEL_BASE_HI;
        L_EXP:   sel = SEL_EXP;
        default: sel = SEL_NONE;
      endcase
    end
  end

  // R2: a selected register always lies in this channel's window
  always_comb begin
    if (sel != SEL_NONE)
      a_r2_window_only: assert (addr[ADDR_W-1:WIN_LOG2] == CH_W'(CHAN_ID));
  end

endmodule

// File: rtl/chan_mode_fsm.sv
module chan_mode_fsm
  import chan_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pkt_done,
  input  logic              err_evt,
  output chan_mode_e        mode,
  output logic              pkt_start,
  output logic              err_clr,
  output logic              phy_rst,
  output logic              chan_rst,
  output logic              err_flag
);
  chan_mode_e mode_q, mode_d;
  logic       mode_en;
  logic       start_q, start_d;
  logic       clr_q, clr_d;
  logic       phy_q, phy_d;
  logic       chn_q, chn_d;
  logic       err_q, err_d, err_en;

  logic ctl0_w, ctl1_w, door_w;
  logic want_reg, do_clr, do_phy, do_chn, do_run, done_hit;

  // next-state logic
  always_comb begin
    ctl0_w   = wr_en && (sel == SEL_CTL0);
    ctl1_w   = wr_en && (sel == SEL_CTL1);
    door_w   = wr_en && (sel == SEL_DOOR);
    want_reg = ctl0_w && wdata[CTL0_REG_BIT];
    do_clr   = ctl0_w && wdata[CTL0_CLR_BIT];
    do_phy   = ctl1_w && wdata[CTL1_PHY_BIT];
    do_chn   = ctl1_w && wdata[CTL1_CHN_BIT];
    do_run   = door_w && (wdata == DATA_W'(DOOR_RUN)) && (mode_q == MODE_REG);
    done_hit = pkt_done && (mode_q == MODE_PKT);

    mode_en = do_chn || want_reg || do_run || done_hit;
    if (do_chn || want_reg)      mode_d = MODE_REG;
    else if (do_run)             mode_d = MODE_PKT;
    else                         mode_d = MODE_REG;

    start_d = do_run && !do_chn;
    clr_d   = do_clr;
    phy_d   = do_phy;
    chn_d   = do_chn;

    err_en = err_evt || do_clr || do_chn;
    err_d  = !(do_clr || do_chn);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_REG;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
      phy_q   <= 1'b0;
      chn_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (err_en)  err_q  <= err_d;
      start_q <= start_d;
      clr_q   <= clr_d;
      phy_q   <= phy_d;
      chn_q   <= chn_d;
    end
  end

  assign mode      = mode_q;
  assign pkt_start = start_q;
  assign err_clr   = clr_q;
  assign phy_rst   = phy_q;
  assign chan_rst  = chn_q;
  assign err_flag  = err_q;

  a_r3_start_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (mode_q == MODE_PKT) && ($past(mode_q) == MODE_REG));

  a_r4_no_double_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  a_r5_done_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PKT && pkt_done) |=> (mode_q == MODE_REG));

  a_r9_chan_rst_effect: assert property (@(posedge clk) disable iff (!rst_n)
    chn_q |-> (mode_q == MODE_REG) && !err_q);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !err_q);

endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
  import chan_ctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int EXP_W     = 8,
  parameter int EXP_RESET = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] base,
  output logic [EXP_W-1:0]    exp_val
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [EXP_W-1:0]  exp_q;
  logic              lo_en, hi_en, exp_en;

  always_comb begin
    lo_en  = wr_en && (sel == SEL_BASE_LO);
    hi_en  = wr_en && (sel == SEL_BASE_HI);
    exp_en = wr_en && (sel == SEL_EXP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      exp_q <= EXP_W'(EXP_RESET);
    end else begin
      if (lo_en)  lo_q  <= wdata;
      if (hi_en)  hi_q  <= wdata;
      if (exp_en) exp_q <= wdata[EXP_W-1:0];
    end
  end

  assign base    = {hi_q, lo_q};
  assign exp_val = exp_q;

  a_r11_halves_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_BASE_LO) |=> $stable(base[2*DATA_W-1:DATA_W]));

  a_r12_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_EXP) |=> $stable(exp_val));

endmodule

// File: rtl/chan_mode_ctl.sv
module chan_mode_ctl
  import chan_ctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int WIN_LOG2  = 14,
  parameter int CHAN_ID   = 0,
  parameter int EXP_W     = 8,
  parameter int EXP_RESET = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                pkt_done,
  input  logic                err_evt,
  output logic                pkt_mode,
  output logic                pkt_start,
  output logic                err_clr,
  output logic                phy_rst,
  output logic                chan_rst,
  output logic                err_flag,
  output logic [2*DATA_W-1:0] cb_base,
  output logic [EXP_W-1:0]    cb_exp
);
  logic       rst_meta, rst_n_s;
  reg_sel_e   sel;
  chan_mode_e mode;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  chan_addr_dec #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .CHAN_ID(CHAN_ID)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  chan_mode_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .sel       (sel),
    .wdata     (wdata),
    .pkt_done  (pkt_done),
    .err_evt   (err_evt),
    .mode      (mode),
    .pkt_start (pkt_start),
    .err_clr   (err_clr),
    .phy_rst   (phy_rst),
    .chan_rst  (chan_rst),
    .err_flag  (err_flag)
  );

  chan_cfg_regs #(.DATA_W(DATA_W), .EXP_W(EXP_W), .EXP_RESET(EXP_RESET)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (wdata),
    .base    (cb_base),
    .exp_val (cb_exp)
  );

  assign pkt_mode = (mode == MODE_PKT);

  // read mux
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTL0:    rdata[CTL0_REG_BIT] = (mode == MODE_REG);
      SEL_BASE_LO: rdata = cb_base[DATA_W-1:0];
      SEL_BASE_HI: rdata = cb_base[2*DATA_W-1:DATA_W];
      SEL_EXP:     rdata = DATA_W'(cb_exp);
      default:     rdata = '0;
    endcase
  end

  // R10: control-0 readback tracks the mode output
  always_comb begin
    if (sel == SEL_CTL0)
      a_r10_ctl0_mode: assert (rdata[CTL0_REG_BIT] == !pkt_mode);
  end

endmodule

// File: tb/tb_chan_mode_ctl.sv
module tb_chan_mode_ctl;
  localparam int CLK_NS = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pkt_done, err_evt;
  logic        pkt_mode, pkt_start, err_clr, phy_rst, chan_rst, err_flag;
  logic [63:0] cb_base;
  logic [7:0]  cb_exp;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #(CLK_NS/2) clk = ~clk;

  chan_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pkt_done(pkt_done), .err_evt(err_evt),
    .pkt_mode(pkt_mode), .pkt_start(pkt_start), .err_clr(err_clr),
    .phy_rst(phy_rst), .chan_rst(chan_rst), .err_flag(err_flag),
    .cb_base(cb_base), .cb_exp(cb_exp)
  );

  // {req[3:0], wr, addr[15:0], wdata[31:0], done, evt,
  //  expected {mode,start,clr,phy,chn,err}}
  localparam logic [60:0] VEC [NV] = '{
    {4'd3,  1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0, 6'b110000}, // R3 launch
    {4'd3,  1'b0, 16'h0000, 32'h000, 1'b0, 1'b0, 6'b100000}, // R3 start lasts one cycle
    {4'd4,  1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0, 6'b100000}, // R4 doorbell in packet mode
    {4'd5,  1'b0, 16'h0000, 32'h000, 1'b1, 1'b0, 6'b000000}, // R5 completion
    {4'd4,  1'b1, 16'h0A00, 32'h106, 1'b0, 1'b0, 6'b000000}, // R4 wrong word
    {4'd2,  1'b1, 16'h4A00, 32'h107, 1'b0, 1'b0, 6'b000000}, // R2 other window
    {4'd3,  1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0, 6'b110000}, // R3 launch again
    {4'd6,  1'b1, 16'h0900, 32'h002, 1'b0, 1'b0, 6'b000000}, // R6 force register mode
    {4'd7,  1'b0, 16'h0000, 32'h000, 1'b0, 1'b1, 6'b000001}, // R7 error latched
    {4'd7,  1'b1, 16'h0900, 32'h004, 1'b0, 1'b0, 6'b001000}, // R7 error clear
    {4'd8,  1'b1, 16'h0901, 32'h002, 1'b0, 1'b0, 6'b000100}, // R8 phy reset
    {4'd7,  1'b0, 16'h0000, 32'h000, 1'b0, 1'b1, 6'b000001}, // R7 error again
    {4'd3,  1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0, 6'b110001}, // R3 launch with error held
    {4'd9,  1'b1, 16'h0901, 32'h010, 1'b0, 1'b0, 6'b000010}, // R9 channel reset
    {4'd5,  1'b0, 16'h0000, 32'h000, 1'b1, 1'b0, 6'b000000}, // R5 done ignored in reg mode
    {4'd8,  1'b1, 16'h0901, 32'h012, 1'b0, 1'b0, 6'b000110}, // R8 R9 both pulses
    {4'd2,  1'b1, 16'h4901, 32'h012, 1'b0, 1'b0, 6'b000000}  // R2 other window control
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at a negedge, sample at the following negedge
  task automatic step(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic dn, input logic ev);
    wr_en = w; addr = a; wdata = d; pkt_done = dn; err_evt = ev;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; pkt_done = 1'b0; err_evt = 1'b0;
  endtask

  function automatic logic [5:0] outs();
    return {pkt_mode, pkt_start, err_clr, phy_rst, chan_rst, err_flag};
  endfunction

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pkt_done = 1'b0; err_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 64'(outs()), 64'h0);
    chk("R1 base", cb_base, 64'h0);
    chk("R1 exp", 64'(cb_exp), 64'd6);
    rd(16'h0900, r); chk("R1 ctl0 read", 64'(r), 64'h2);
    rd(16'h0718, r); chk("R1 exp read", 64'(r), 64'd6);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      v = VEC[i];
      step(v[56], v[55:40], v[39:8], v[7], v[6]);
      n_chk++;
      if (outs() !== v[5:0]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b", v[60:57], i, outs(), v[5:0]);
      end
    end

    // R11 base halves
    step(1'b1, 16'h0710, 32'hDEAD_BEEF, 1'b0, 1'b0);
    chk("R11 low half", cb_base, 64'h0000_0000_DEAD_BEEF);
    step(1'b1, 16'h0714, 32'h1234_5678, 1'b0, 1'b0);
    chk("R11 high half", cb_base, 64'h1234_5678_DEAD_BEEF);
    step(1'b1, 16'h0710, 32'h0000_0040, 1'b0, 1'b0);
    chk("R11 low rewrite keeps high", cb_base, 64'h1234_5678_0000_0040);
    rd(16'h0714, r); chk("R11 high read", 64'(r), 64'h1234_5678);
    rd(16'h0710, r); chk("R11 low read", 64'(r), 64'h40);

    // R12 exponent
    step(1'b1, 16'h0718, 32'h0000_000C, 1'b0, 1'b0);
    chk("R12 exp out", 64'(cb_exp), 64'd12);
    rd(16'h0718, r); chk("R12 exp read", 64'(r), 64'd12);

    // R10 readback in packet mode and pulse bits
    step(1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0);
    rd(16'h0900, r); chk("R10 ctl0 in packet mode", 64'(r), 64'h0);
    rd(16'h0901, r); chk("R10 ctl1 reads zero", 64'(r), 64'h0);
    step(1'b1, 16'h0901, 32'h012, 1'b0, 1'b0);
    rd(16'h0901, r); chk("R10 ctl1 after pulse write", 64'(r), 64'h0);
    rd(16'h0900, r); chk("R10 ctl0 back in reg mode", 64'(r), 64'h2);

    // R7 clear and event in the same cycle: clear wins
    step(1'b0, 16'h0000, 32'h0, 1'b0, 1'b1);
    wr_en = 1'b1; addr = 16'h0900; wdata = 32'h004; err_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; err_evt = 1'b0;
    chk("R7 clear beats event", 64'({err_clr, err_flag}), 64'b10);

    // R1 asynchronous reset while in packet mode
    step(1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0);
    chk("R1 packet mode before reset", 64'(pkt_mode), 64'd1);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async reset to reg mode", 64'(pkt_mode), 64'd0);
    chk("R1 exp after reset", 64'(cb_exp), 64'd6);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 16'h0A00, 32'h107, 1'b0, 1'b0);
    chk("R3 launch after reset", 64'({pkt_mode, pkt_start}), 64'b11);

    finish_run();
  end
endmodule